// File: doc/BRIEF.md
# Dual-Category Top-Four Candidate Selector

Once per event this block takes every electron candidate from a set of calorimeter crates, all in parallel, and reports the four strongest. It keeps two categories, isolated and non-isolated, and each has its own candidates and its own four-entry result list. The two never interact. Each candidate has a valid flag, an energy rank and a position code. An event strobe marks the cycle in which the inputs hold an event.

The selection is a fixed-latency pipeline. With default parameters the result appears two clock edges after the event is presented, and a new event may be presented in every cycle. The strongest candidate is placed in slot 0, and the list runs in descending order. A run-time key select picks the sorting criterion:

- **Energy-only ordering:** candidates are ordered by rank alone.
- **Energy-then-position ordering:** the position code breaks ties in rank.

In both modes any tie that remains goes to the lowest input index. This keeps the output deterministic. The crate count, candidates per crate, field widths, list length and the grouping of the first pipeline stage are all parameters.

Top module: `cand_top4_sorter`

## Requirements
- R1: For each category, output slots 0..3 hold the four best valid candidates of the event, with slot 0 best. Ranks do not increase from slot k to slot k+1.
- R2: A candidate with its valid bit low never appears in the output, whatever its rank or position. Any slot left unfilled reads valid 0, rank 0 and position 0.
- R3: When two candidates have equal keys, the one with the lower input index wins. Candidate j of crate c has input index c*4+j.
- R4: With key_sel = 0 the key is the rank alone and the position has no effect on order. With key_sel = 1 a larger position code wins among equal ranks. key_sel is sampled together with the event.
- R5: The isolated and non-isolated categories are selected independently. The inputs of one category never change the output list of the other.
- R6: An event presented with evt_valid high in cycle n produces its lists and out_strobe high after exactly two rising clock edges. Events may arrive in consecutive cycles with no gap.
- R7: When evt_valid is low, the candidate inputs are ignored. Two edges later out_strobe is low and every output slot is invalid.
- R8: While rst_n is low, out_strobe and all output slot fields are 0.
- R9: The number of valid output slots in a category equals the number of valid input candidates in that category, capped at 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Event strobe; candidate inputs hold an event this cycle |
| key_sel | input | 1 | Sort key: 0 rank only, 1 rank then position |
| iso_vld | input | 36 | Valid flags of isolated candidates, bit i is input index i |
| iso_rank | input | 36x6 | Energy ranks of isolated candidates |
| iso_pos | input | 36x9 | Position codes of isolated candidates |
| niso_vld | input | 36 | Valid flags of non-isolated candidates |
| niso_rank | input | 36x6 | Energy ranks of non-isolated candidates |
| niso_pos | input | 36x9 | Position codes of non-isolated candidates |
| out_strobe | output | 1 | High when the output lists belong to an event |
| iso_top_vld | output | 4 | Valid flag of each isolated result slot |
| iso_top_rank | output | 4x6 | Rank of each isolated result slot |
| iso_top_pos | output | 4x9 | Position of each isolated result slot |
| niso_top_vld | output | 4 | Valid flag of each non-isolated result slot |
| niso_top_rank | output | 4x6 | Rank of each non-isolated result slot |
| niso_top_pos | output | 4x9 | Position of each non-isolated result slot |

## Verification
The bench targets the following corner cases, each with the failure it would expose:

- **Tied ranks.** Equal ranks across the whole event, and a small rank range that forces frequent ties. A tie-break that is not strict would drop or duplicate a candidate, and a reversed tie-break would report high indices.
- **Invalid candidates at full rank.** A design that ignores the valid flag would pull these into the list.
- **Partly filled lists.** Events with zero to three valid candidates check that empty slots read as zero.
- **Key select with mixed positions.** Toggling key_sel over equal ranks and differing positions shows whether position is wrongly ignored or wrongly used.
- **Strobe-low cycles and category isolation.** Strobe-low cycles between back-to-back events, and events where one category is empty, catch latency slips and crosstalk between the two lists.

// File: rtl/cand_sort_pkg.sv
package cand_sort_pkg;

   // Run-time ordering criterion
   typedef enum logic {
      KEY_RANK_ONLY = 1'b0,
      KEY_RANK_POS  = 1'b1
   } key_mode_e;

   // Counter width able to hold the value m
   function automatic int cnt_width(input int m);
      return (m < 2) ? 1 : $clog2(m + 1);
   endfunction

endpackage

// File: rtl/cand_topk_select.sv
// Registered selection of the K best of M packed candidates.
// Candidate layout: {valid, rank, position}; lower array index wins ties.
module cand_topk_select
   import cand_sort_pkg::*;
#(
   parameter int M     = 12,
   parameter int K     = 4,
   parameter int CW    = 16,
   parameter int POS_W = 9
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 key_sel,
   input  logic [M-1:0][CW-1:0] in_c,
   output logic [K-1:0][CW-1:0] out_c
);
   localparam int PL_W = cnt_width(M);

   if (K > M) begin : g_bad_k
      $error("cand_topk_select: K larger than M");
   end
   if (POS_W >= CW) begin : g_bad_w
      $error("cand_topk_select: POS_W must be below CW");
   end

   logic [M-1:0][CW-1:0]   key;
   logic [M-1:0][PL_W-1:0] place;
   logic [K-1:0][CW-1:0]   nxt;

   // Position bits take part in the key only when key_sel selects it
   always_comb begin
      for (int i = 0; i < M; i++) begin
         key[i] = (key_mode_e'(key_sel) == KEY_RANK_POS) ? in_c[i]
                  : {in_c[i][CW-1:POS_W], {POS_W{1'b0}}};
      end
   end

   // place[i] = number of candidates that beat candidate i
   always_comb begin
      for (int i = 0; i < M; i++) begin
         place[i] = '0;
         for (int j = 0; j < M; j++) begin
            if (j < i) begin
               if (key[j] >= key[i]) place[i] = place[i] + PL_W'(1);
            end else if (j > i) begin
               if (key[j] > key[i]) place[i] = place[i] + PL_W'(1);
            end
         end
      end
   end

   // Each slot collects the unique candidate whose place matches it
   always_comb begin
      for (int k = 0; k < K; k++) begin
         nxt[k] = '0;
         for (int i = 0; i < M; i++) begin
            if (place[i] == PL_W'(k)) nxt[k] = nxt[k] | in_c[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_c <= '0;
      else        out_c <= nxt;
   end

endmodule

// File: rtl/cand_cat_sorter.sv
// One category: grouped first stage, then a root stage over group winners.
module cand_cat_sorter #(
   parameter int N_CRATES     = 9,
   parameter int PER_CRATE    = 4,
   parameter int GROUP_CRATES = 3,
   parameter int K            = 4,
   parameter int CW           = 16,
   parameter int POS_W        = 9
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  sel_s1,
   input  logic                                  sel_s2,
   input  logic [N_CRATES*PER_CRATE-1:0][CW-1:0] in_c,
   output logic [K-1:0][CW-1:0]                  out_c
);
   localparam int NG = N_CRATES / GROUP_CRATES;
   localparam int GM = GROUP_CRATES * PER_CRATE;

   if (NG == 1) begin : g_flat
      cand_topk_select #(.M(GM), .K(K), .CW(CW), .POS_W(POS_W)) u_root (
         .clk(clk), .rst_n(rst_n), .key_sel(sel_s1), .in_c(in_c), .out_c(out_c)
      );
   end else begin : g_tree
      logic [NG*K-1:0][CW-1:0] part;
      for (genvar g = 0; g < NG; g++) begin : g_leaf
         cand_topk_select #(.M(GM), .K(K), .CW(CW), .POS_W(POS_W)) u_leaf (
            .clk(clk), .rst_n(rst_n), .key_sel(sel_s1),
            .in_c(in_c[g*GM +: GM]), .out_c(part[g*K +: K])
         );
      end
      cand_topk_select #(.M(NG*K), .K(K), .CW(CW), .POS_W(POS_W)) u_root (
         .clk(clk), .rst_n(rst_n), .key_sel(sel_s2), .in_c(part), .out_c(out_c)
      );
   end

endmodule

// File: rtl/cand_top4_sorter.sv
module cand_top4_sorter #(
   parameter int N_CRATES     = 9,
   parameter int PER_CRATE    = 4,
   parameter int GROUP_CRATES = 3,
   parameter int RANK_W       = 6,
   parameter int POS_W        = 9,
   parameter int TOP_N        = 4
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      evt_valid,
   input  logic                                      key_sel,
   input  logic [N_CRATES*PER_CRATE-1:0]             iso_vld,
   input  logic [N_CRATES*PER_CRATE-1:0][RANK_W-1:0] iso_rank,
   input  logic [N_CRATES*PER_CRATE-1:0][POS_W-1:0]  iso_pos,
   input  logic [N_CRATES*PER_CRATE-1:0]             niso_vld,
   input  logic [N_CRATES*PER_CRATE-1:0][RANK_W-1:0] niso_rank,
   input  logic [N_CRATES*PER_CRATE-1:0][POS_W-1:0]  niso_pos,
   output logic                                      out_strobe,
   output logic [TOP_N-1:0]                          iso_top_vld,
   output logic [TOP_N-1:0][RANK_W-1:0]              iso_top_rank,
   output logic [TOP_N-1:0][POS_W-1:0]               iso_top_pos,
   output logic [TOP_N-1:0]                          niso_top_vld,
   output logic [TOP_N-1:0][RANK_W-1:0]              niso_top_rank,
   output logic [TOP_N-1:0][POS_W-1:0]               niso_top_pos
);
   localparam int NCAND = N_CRATES * PER_CRATE;
   localparam int CW    = 1 + RANK_W + POS_W;
   localparam int NG    = N_CRATES / GROUP_CRATES;
   localparam int LAT   = (NG > 1) ? 2 : 1;

   if (N_CRATES % GROUP_CRATES != 0) begin : g_bad_group
      $error("cand_top4_sorter: GROUP_CRATES must divide N_CRATES");
   end
   if (TOP_N > GROUP_CRATES * PER_CRATE) begin : g_bad_top
      $error("cand_top4_sorter: TOP_N exceeds candidates per group");
   end

   logic [1:0][NCAND-1:0][CW-1:0] cin;
   logic [1:0][TOP_N-1:0][CW-1:0] cout;
   logic                          sel_q;
   logic [LAT-1:0]                strb;

   // Invalid or strobe-less candidates become all-zero: lowest possible key
   always_comb begin
      for (int i = 0; i < NCAND; i++) begin
         cin[0][i] = (evt_valid && iso_vld[i])  ? {1'b1, iso_rank[i],  iso_pos[i]}  : '0;
         cin[1][i] = (evt_valid && niso_vld[i]) ? {1'b1, niso_rank[i], niso_pos[i]} : '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= 1'b0;
         strb  <= '0;
      end else begin
         sel_q <= key_sel;
         strb  <= (strb << 1) | LAT'(evt_valid);
      end
   end

   assign out_strobe = strb[LAT-1];

   for (genvar c = 0; c < 2; c++) begin : g_cat
      cand_cat_sorter #(
         .N_CRATES(N_CRATES), .PER_CRATE(PER_CRATE), .GROUP_CRATES(GROUP_CRATES),
         .K(TOP_N), .CW(CW), .POS_W(POS_W)
      ) u_cat (
         .clk(clk), .rst_n(rst_n), .sel_s1(key_sel), .sel_s2(sel_q),
         .in_c(cin[c]), .out_c(cout[c])
      );
   end

   always_comb begin
      for (int k = 0; k < TOP_N; k++) begin
         iso_top_vld[k]   = cout[0][k][CW-1];
         iso_top_rank[k]  = cout[0][k][POS_W +: RANK_W];
         iso_top_pos[k]   = cout[0][k][POS_W-1:0];
         niso_top_vld[k]  = cout[1][k][CW-1];
         niso_top_rank[k] = cout[1][k][POS_W +: RANK_W];
         niso_top_pos[k]  = cout[1][k][POS_W-1:0];
      end
   end

endmodule

// File: rtl/cand_top4_sorter_chk.sv
module cand_top4_sorter_chk #(
   parameter int N_CRATES     = 9,
   parameter int PER_CRATE    = 4,
   parameter int GROUP_CRATES = 3,
   parameter int RANK_W       = 6,
   parameter int POS_W        = 9,
   parameter int TOP_N        = 4
) (
   input logic                                      clk,
   input logic                                      rst_n,
   input logic                                      evt_valid,
   input logic [N_CRATES*PER_CRATE-1:0]             iso_vld,
   input logic [N_CRATES*PER_CRATE-1:0][RANK_W-1:0] iso_rank,
   input logic [N_CRATES*PER_CRATE-1:0]             niso_vld,
   input logic [N_CRATES*PER_CRATE-1:0][RANK_W-1:0] niso_rank,
   input logic                                      out_strobe,
   input logic [TOP_N-1:0]                          iso_top_vld,
   input logic [TOP_N-1:0][RANK_W-1:0]              iso_top_rank,
   input logic [TOP_N-1:0][POS_W-1:0]               iso_top_pos,
   input logic [TOP_N-1:0]                          niso_top_vld,
   input logic [TOP_N-1:0][RANK_W-1:0]              niso_top_rank,
   input logic [TOP_N-1:0][POS_W-1:0]               niso_top_pos
);
   localparam int NC  = N_CRATES * PER_CRATE;
   localparam int LAT = (N_CRATES / GROUP_CRATES > 1) ? 2 : 1;
   localparam int FW  = $clog2(TOP_N + 1);
   localparam int NW  = $clog2(NC + 1);

   logic [1:0][NC-1:0]                cv;
   logic [1:0][NC-1:0][RANK_W-1:0]    cr;
   logic [1:0][TOP_N-1:0]             ov;
   logic [1:0][TOP_N-1:0][RANK_W-1:0] orank;
   logic [1:0][TOP_N-1:0][POS_W-1:0]  opos;
   logic [1:0][NW-1:0]                n_now;
   logic [1:0][FW-1:0]                fill_now;
   logic [1:0][RANK_W-1:0]            max_now;
   logic [1:0][1:0][FW-1:0]           fill_sh;
   logic [1:0][1:0][RANK_W-1:0]       max_sh;
   logic [1:0]                        ev_sh;
   logic [1:0][FW-1:0]                fill_exp;
   logic [1:0][RANK_W-1:0]            max_exp;
   logic                              ev_exp;

   assign cv    = {niso_vld, iso_vld};
   assign cr    = {niso_rank, iso_rank};
   assign ov    = {niso_top_vld, iso_top_vld};
   assign orank = {niso_top_rank, iso_top_rank};
   assign opos  = {niso_top_pos, iso_top_pos};

   // Independent per-event summary: valid count (capped) and maximum rank
   always_comb begin
      for (int c = 0; c < 2; c++) begin
         n_now[c]   = '0;
         max_now[c] = '0;
         for (int i = 0; i < NC; i++) begin
            if (evt_valid && cv[c][i]) begin
               n_now[c] = n_now[c] + NW'(1);
               if (cr[c][i] > max_now[c]) max_now[c] = cr[c][i];
            end
         end
         fill_now[c] = (int'(n_now[c]) > TOP_N) ? FW'(TOP_N) : FW'(n_now[c]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_sh <= '0;
         max_sh  <= '0;
         ev_sh   <= '0;
      end else begin
         fill_sh[1] <= fill_sh[0];
         fill_sh[0] <= fill_now;
         max_sh[1]  <= max_sh[0];
         max_sh[0]  <= max_now;
         ev_sh      <= {ev_sh[0], evt_valid};
      end
   end

   assign fill_exp = (LAT == 2) ? fill_sh[1] : fill_sh[0];
   assign max_exp  = (LAT == 2) ? max_sh[1]  : max_sh[0];
   assign ev_exp   = (LAT == 2) ? ev_sh[1]   : ev_sh[0];

   assert_strobe_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_strobe == ev_exp);

   for (genvar c = 0; c < 2; c++) begin : g_c
      assert_fill_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(ov[c]) == int'(fill_exp[c]));
      assert_idle_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !out_strobe |-> (ov[c] == '0));
      assert_top_max_R1: assert property (@(posedge clk) disable iff (!rst_n)
         ov[c][0] |-> (orank[c][0] == max_exp[c]));
      for (genvar k = 0; k < TOP_N; k++) begin : g_k
         assert_empty_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !ov[c][k] |-> (orank[c][k] == '0 && opos[c][k] == '0));
         if (k + 1 < TOP_N) begin : g_ord
            assert_desc_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
               ov[c][k+1] |-> (ov[c][k] && orank[c][k] >= orank[c][k+1]));
         end
      end
   end

endmodule

bind cand_top4_sorter cand_top4_sorter_chk #(
   .N_CRATES(N_CRATES), .PER_CRATE(PER_CRATE), .GROUP_CRATES(GROUP_CRATES),
   .RANK_W(RANK_W), .POS_W(POS_W), .TOP_N(TOP_N)
) u_chk (
   .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid),
   .iso_vld(iso_vld), .iso_rank(iso_rank),
   .niso_vld(niso_vld), .niso_rank(niso_rank),
   .out_strobe(out_strobe),
   .iso_top_vld(iso_top_vld), .iso_top_rank(iso_top_rank), .iso_top_pos(iso_top_pos),
   .niso_top_vld(niso_top_vld), .niso_top_rank(niso_top_rank), .niso_top_pos(niso_top_pos)
);

// File: tb/cand_top4_sorter_bench.sv
module cand_top4_sorter_bench;
   localparam int NC = 36;
   localparam int K  = 4;
   localparam int RW = 6;
   localparam int PW = 9;

   typedef struct {
      logic                      strobe;
      logic [1:0][K-1:0]         v;
      logic [1:0][K-1:0][RW-1:0] r;
      logic [1:0][K-1:0][PW-1:0] p;
      string                     tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic evt = 1'b0;
   logic sel = 1'b0;
   logic [1:0][NC-1:0]         in_v = '0;
   logic [1:0][NC-1:0][RW-1:0] in_r = '0;
   logic [1:0][NC-1:0][PW-1:0] in_p = '0;
   logic                       o_strobe;
   logic [1:0][K-1:0]          o_v;
   logic [1:0][K-1:0][RW-1:0]  o_r;
   logic [1:0][K-1:0][PW-1:0]  o_p;

   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;
   exp_t q[$];

   always #4 clk = ~clk;

   cand_top4_sorter u_cand_top4_sorter (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt), .key_sel(sel),
      .iso_vld(in_v[0]), .iso_rank(in_r[0]), .iso_pos(in_p[0]),
      .niso_vld(in_v[1]), .niso_rank(in_r[1]), .niso_pos(in_p[1]),
      .out_strobe(o_strobe),
      .iso_top_vld(o_v[0]), .iso_top_rank(o_r[0]), .iso_top_pos(o_p[0]),
      .niso_top_vld(o_v[1]), .niso_top_rank(o_r[1]), .niso_top_pos(o_p[1])
   );

   // Behavioural reference: repeated search for the best unused candidate
   function automatic exp_t model(string tag);
      exp_t e;
      e.tag = tag;
      e.strobe = evt;
      e.v = '0; e.r = '0; e.p = '0;
      for (int c = 0; c < 2; c++) begin
         bit [NC-1:0] used = '0;
         for (int s = 0; s < K; s++) begin
            int best = -1;
            for (int i = 0; i < NC; i++) begin
               if (evt && in_v[c][i] && !used[i]) begin
                  if (best < 0 || in_r[c][i] > in_r[c][best] ||
                      (sel && in_r[c][i] == in_r[c][best] && in_p[c][i] > in_p[c][best]))
                     best = i;
               end
            end
            if (best >= 0) begin
               used[best] = 1'b1;
               e.v[c][s] = 1'b1;
               e.r[c][s] = in_r[c][best];
               e.p[c][s] = in_p[c][best];
            end
         end
      end
      return e;
   endfunction

   task automatic compare(exp_t e);
      checks++;
      if (o_strobe !== e.strobe) begin
         errors++;
         $display("FAIL %s strobe: act=%0b exp=%0b", e.tag, o_strobe, e.strobe);
      end
      for (int c = 0; c < 2; c++) begin
         checks++;
         if (o_v[c] !== e.v[c] || o_r[c] !== e.r[c] || o_p[c] !== e.p[c]) begin
            errors++;
            $display("FAIL %s cat%0d: act v=%b r=%h p=%h exp v=%b r=%h p=%h",
                     e.tag, c, o_v[c], o_r[c], o_p[c], e.v[c], e.r[c], e.p[c]);
         end
      end
   endtask

   // Inputs are set just after a falling edge; results arrive two edges later
   task automatic step(string tag);
      q.push_back(model(tag));
      @(negedge clk);
      if (q.size() >= 2) compare(q.pop_front());
   endtask

   task automatic clear_in();
      in_v = '0; in_r = '0; in_p = '0;
   endtask

   task automatic fill(int c, int max_rank, int pct_valid);
      for (int i = 0; i < NC; i++) begin
         in_v[c][i] = ($urandom_range(99) < pct_valid);
         in_r[c][i] = RW'($urandom_range(max_rank));
         in_p[c][i] = PW'($urandom);
      end
   endtask

   initial begin
      exp_t idle;
      idle.strobe = 1'b0; idle.v = '0; idle.r = '0; idle.p = '0; idle.tag = "R8";
      // R8: reset state
      fill(0, 63, 100); fill(1, 63, 100); evt = 1'b1;
      repeat (2) @(negedge clk);
      compare(idle);
      evt = 1'b0; clear_in();
      @(negedge clk);
      rst_n = 1'b1;
      compare(idle);

      // R1: full events with wide rank spread
      for (int n = 0; n < 6; n++) begin
         evt = 1'b1; fill(0, 63, 100); fill(1, 63, 100); step("R1");
      end
      // R2 R9: few valid candidates, invalid ones carry maximum rank
      for (int nv = 0; nv < 6; nv++) begin
         clear_in();
         for (int c = 0; c < 2; c++)
            for (int i = 0; i < NC; i++) begin
               in_r[c][i] = 6'd63; in_p[c][i] = PW'($urandom);
            end
         for (int m = 0; m < nv; m++) begin
            int idx = $urandom_range(NC - 1);
            in_v[0][idx] = 1'b1; in_r[0][idx] = RW'($urandom_range(20));
            idx = $urandom_range(NC - 1);
            in_v[1][idx] = 1'b1; in_r[1][idx] = RW'($urandom_range(20));
         end
         step("R2 R9");
      end
      // R3: all ranks equal, then equal top ranks spread over high indices
      fill(0, 63, 100); fill(1, 63, 100);
      for (int i = 0; i < NC; i++) begin in_r[0][i] = 6'd17; in_r[1][i] = 6'd17; end
      step("R3");
      for (int i = 0; i < NC; i++) begin
         in_r[0][i] = (i % 7 == 3) ? 6'd40 : 6'd5;
         in_r[1][i] = (i > 30) ? 6'd40 : 6'd5;
      end
      step("R3");
      // R4: equal ranks, positions decide only with key_sel = 1
      for (int n = 0; n < 3; n++) begin
         fill(0, 63, 100); fill(1, 63, 100);
         for (int i = 0; i < NC; i++) begin in_r[0][i] = 6'd9; in_r[1][i] = RW'(i % 3); end
         sel = 1'b1; step("R4");
         sel = 1'b0; step("R4");
      end
      // R5: one category empty, the other full, both ways
      clear_in(); fill(0, 63, 100); step("R5");
      clear_in(); fill(1, 63, 100); step("R5");
      // R7: strobe low with valid-looking inputs, between events
      fill(0, 63, 100); fill(1, 63, 100);
      evt = 1'b0; step("R7"); step("R7");
      evt = 1'b1; step("R7");
      // R6: back-to-back mixed traffic with frequent ties
      for (int n = 0; n < 150; n++) begin
         evt = ($urandom_range(9) != 0);
         sel = $urandom_range(1);
         fill(0, 7, $urandom_range(100)); fill(1, 7, $urandom_range(100));
         step("R6");
      end
      evt = 1'b0; clear_in();
      repeat (3) step("R6");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R6 watchdog: act=running exp=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule